// File: doc/BRIEF.md
# Segmented DAC Input Decoder

This block is the digital front end of a 12-bit segmented current-steering converter. It takes a 12-bit word and a latch-enable control, and produces the switch controls for three segments. The top four bits become a 15-line thermometer code that drives equal-weight current cells. The next two bits drive two binary-weighted cells. The six lowest bits pass straight to a ladder. The eight undecoded bits and the latch enable go through an equalizing delay that matches the decoder's register stage. Because of this delay, every switch control changes on the same clock edge.

An output latch holds all switch controls. It has two named states: `LM_TRACK` follows the aligned latch-enable when it is low, and `LM_HOLD` freezes the controls while it is high. There is one transition in each direction between them, `LM_TRACK -> LM_HOLD` and `LM_HOLD -> LM_TRACK`, and the delayed latch enable selects it on every cycle.

When `IN_REG` is set (the default), an input register works in antiphase to the latch. It captures the word only while latch enable is high, and the latch passes data only while latch enable is low. This gives master-slave, edge-triggered operation. For checking, the block also reports a numeric model of the true and complementary output current levels, in LSB units.

Top module: `seg_dac_front`

## Requirements
- R1: `din_i[11]` is the most significant bit. The count of asserted `therm_o` lines equals `din_i[11:8]`, and line i (bit i) is asserted exactly when that value exceeds i, so the lines fill from bit 0 upward.
- R2: `bin_o[1]` carries `din_i[7]` (weight 128) and `bin_o[0]` carries `din_i[6]` (weight 64).
- R3: `ladder_o` equals `din_i[5:0]`, with bit order kept.
- R4: All segment controls change on the same clock edge. In registered mode, a word captured at rising edge k, with `le_i` low at edge k+1, is still absent after edge k+2 and appears on every output after edge k+3.
- R5: While the latch enable seen at the latch is high (`le_i` two edges earlier), the latch is in `LM_HOLD` and all outputs keep their values whatever `din_i` does.
- R6: In registered mode, the input register loads `din_i` only on edges where `le_i` is high. Changes on `din_i` while `le_i` stays low leave the outputs unchanged.
- R7: `iout_o` equals 256 times the thermometer count, plus 128·`bin_o[1]`, plus 64·`bin_o[0]`, plus `ladder_o`. After a word is latched, this equals the word, for all 4096 codes.
- R8: `iout_o + iout_n_o` is always 4095, which is full scale minus one LSB. All-ones gives `iout_o`=4095 and `iout_n_o`=0; all-zeros gives the reverse.
- R9: A synchronous active-high `rst` clears the input register, the pipeline and the latch. After the reset edge, `therm_o`=0, `bin_o`=0, `ladder_o`=0, `iout_o`=0 and `iout_n_o`=4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din_i | input | 12 | Input word, bit 11 most significant |
| le_i | input | 1 | Latch enable: high holds the latch, low lets it pass; high also opens the input register |
| therm_o | output | 15 | Thermometer switch controls for the equal-weight cells |
| bin_o | output | 2 | Binary-weighted switch controls (bit 1 = weight 128) |
| ladder_o | output | 6 | Ladder switch controls |
| iout_o | output | 12 | Model of the true output current, in LSB |
| iout_n_o | output | 12 | Model of the complementary output current, in LSB |

## Verification
A word is written by driving it with `le_i` high before rising edge k, then lowering `le_i` before edge k+1. The output latch loads at edge k+3. The bench therefore samples on the falling edge after k+2, expecting the previous word on every segment, and again after k+3, expecting the new one on all of them. The hold and input-register checks compare the outputs on each falling edge of a multi-cycle window against the last latched word. The reset check samples on the falling edge straight after the reset edge.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
    localparam int SEG_BITS_D = 4;
    localparam int BIN_BITS_D = 2;
    localparam int LAD_BITS_D = 6;

    typedef enum logic {
        LM_TRACK = 1'b0,
        LM_HOLD  = 1'b1
    } latch_mode_e;
endpackage

// File: rtl/seg_therm_dec.sv
module seg_therm_dec #(
    parameter int SEG_BITS = 4,
    parameter int LINES    = (1 << SEG_BITS) - 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SEG_BITS-1:0] code_i,
    output logic [LINES-1:0]    therm_o
);
    logic [LINES-1:0] line_c;

    // Line i is on when the segment value exceeds i.
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign line_c[i] = (code_i > SEG_BITS'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) therm_o <= '0;
        else     therm_o <= line_c;
    end
endmodule

// File: rtl/seg_delay_line.sv
module seg_delay_line #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic [WIDTH-1:0] src;
        if (i == 0) begin : g_head
            assign src = d_i;
        end else begin : g_body
            assign src = stg[i-1];
        end
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= src;
        end
    end

    assign q_o = stg[DEPTH-1];
endmodule

// File: rtl/seg_current_model.sv
module seg_current_model #(
    parameter int SEG_BITS = 4,
    parameter int BIN_BITS = 2,
    parameter int LAD_BITS = 6,
    parameter int LINES    = (1 << SEG_BITS) - 1,
    parameter int WORD_W   = SEG_BITS + BIN_BITS + LAD_BITS
) (
    input  logic [LINES-1:0]    therm_i,
    input  logic [BIN_BITS-1:0] bin_i,
    input  logic [LAD_BITS-1:0] ladder_i,
    output logic [WORD_W-1:0]   iout_o,
    output logic [WORD_W-1:0]   iout_n_o
);
    localparam logic [WORD_W-1:0] FULL_M1 = {WORD_W{1'b1}};

    logic [SEG_BITS-1:0] cells_on;

    always_comb begin
        cells_on = '0;
        for (int i = 0; i < LINES; i++) begin
            cells_on = cells_on + SEG_BITS'(therm_i[i]);
        end
    end

    assign iout_o   = {cells_on, bin_i, ladder_i};
    assign iout_n_o = FULL_M1 - iout_o;
endmodule

// File: rtl/seg_dac_front.sv
module seg_dac_front
    import seg_dac_pkg::*;
#(
    parameter int SEG_BITS = SEG_BITS_D,
    parameter int BIN_BITS = BIN_BITS_D,
    parameter int LAD_BITS = LAD_BITS_D,
    parameter bit IN_REG   = 1'b1,
    parameter int WORD_W   = SEG_BITS + BIN_BITS + LAD_BITS,
    parameter int LINES    = (1 << SEG_BITS) - 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [WORD_W-1:0]   din_i,
    input  logic                le_i,
    output logic [LINES-1:0]    therm_o,
    output logic [BIN_BITS-1:0] bin_o,
    output logic [LAD_BITS-1:0] ladder_o,
    output logic [WORD_W-1:0]   iout_o,
    output logic [WORD_W-1:0]   iout_n_o
);
    localparam int LOW_W   = BIN_BITS + LAD_BITS;
    localparam int DEC_LAT = 1;

    logic [WORD_W-1:0] din_q;
    logic              le_q;
    logic [LINES-1:0]  therm_q;
    logic [LOW_W-1:0]  low_q;
    logic              le_d;

    latch_mode_e      mode;
    logic [LINES-1:0] therm_lat, therm_nx;
    logic [LOW_W-1:0] low_lat, low_nx;

    // Input stage: master register open while le_i is high, or a bypass.
    if (IN_REG) begin : g_master
        always_ff @(posedge clk) begin
            if (rst) begin
                din_q <= '0;
                le_q  <= 1'b0;
            end else begin
                le_q <= le_i;
                if (le_i) din_q <= din_i;
            end
        end
    end else begin : g_bypass
        assign din_q = din_i;
        assign le_q  = le_i;
    end

    seg_therm_dec #(
        .SEG_BITS (SEG_BITS),
        .LINES    (LINES)
    ) u_dec (
        .clk     (clk),
        .rst     (rst),
        .code_i  (din_q[WORD_W-1 -: SEG_BITS]),
        .therm_o (therm_q)
    );

    // Equalizing delay for the undecoded bits and latch enable.
    seg_delay_line #(
        .WIDTH (LOW_W + 1),
        .DEPTH (DEC_LAT)
    ) u_eq (
        .clk (clk),
        .rst (rst),
        .d_i ({le_q, din_q[LOW_W-1:0]}),
        .q_o ({le_d, low_q})
    );

    assign mode = le_d ? LM_HOLD : LM_TRACK;

    always_comb begin
        therm_nx = therm_lat;
        low_nx   = low_lat;
        unique case (mode)
            LM_TRACK: begin
                therm_nx = therm_q;
                low_nx   = low_q;
            end
            LM_HOLD: begin
                therm_nx = therm_lat;
                low_nx   = low_lat;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            therm_lat <= '0;
            low_lat   <= '0;
        end else begin
            therm_lat <= therm_nx;
            low_lat   <= low_nx;
        end
    end

    assign therm_o  = therm_lat;
    assign bin_o    = low_lat[LOW_W-1 -: BIN_BITS];
    assign ladder_o = low_lat[LAD_BITS-1:0];

    seg_current_model #(
        .SEG_BITS (SEG_BITS),
        .BIN_BITS (BIN_BITS),
        .LAD_BITS (LAD_BITS),
        .LINES    (LINES),
        .WORD_W   (WORD_W)
    ) u_model (
        .therm_i  (therm_lat),
        .bin_i    (bin_o),
        .ladder_i (ladder_o),
        .iout_o   (iout_o),
        .iout_n_o (iout_n_o)
    );
endmodule

// File: rtl/seg_dac_front_chk.sv
module seg_dac_front_chk #(
    parameter int WORD_W   = 12,
    parameter int LINES    = 15,
    parameter int BIN_BITS = 2,
    parameter int LAD_BITS = 6,
    parameter int LE_LAT   = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                le_i,
    input logic [LINES-1:0]    therm_o,
    input logic [BIN_BITS-1:0] bin_o,
    input logic [LAD_BITS-1:0] ladder_o,
    input logic [WORD_W-1:0]   iout_o,
    input logic [WORD_W-1:0]   iout_n_o
);
    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (rst)              warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    p_therm_fill_r1: assert property (@(posedge clk) disable iff (rst)
        (therm_o & LINES'(therm_o + LINES'(1))) == '0);

    p_sum_full_r8: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, iout_o} + {1'b0, iout_n_o}) == {1'b0, {WORD_W{1'b1}}});

    p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && $past(le_i, LE_LAT)) |=>
            ($stable(therm_o) && $stable(bin_o) && $stable(ladder_o)));

    p_reset_clear_r9: assert property (@(posedge clk)
        $past(rst) |-> (therm_o == '0 && iout_o == '0 && iout_n_o == {WORD_W{1'b1}}));
endmodule

bind seg_dac_front seg_dac_front_chk #(
    .WORD_W   (WORD_W),
    .LINES    (LINES),
    .BIN_BITS (BIN_BITS),
    .LAD_BITS (LAD_BITS),
    .LE_LAT   (IN_REG ? 2 : 1)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .le_i     (le_i),
    .therm_o  (therm_o),
    .bin_o    (bin_o),
    .ladder_o (ladder_o),
    .iout_o   (iout_o),
    .iout_n_o (iout_n_o)
);

// File: tb/tb_seg_dac_front.sv
module tb_seg_dac_front;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] din = '0;
    logic        le  = 1'b0;
    logic [14:0] therm_o;
    logic [1:0]  bin_o;
    logic [5:0]  ladder_o;
    logic [11:0] iout_o, iout_n_o;

    int total = 0;
    int bad   = 0;
    logic [11:0] last = '0;

    always #5 clk = ~clk;

    seg_dac_front dut (
        .clk      (clk),
        .rst      (rst),
        .din_i    (din),
        .le_i     (le),
        .therm_o  (therm_o),
        .bin_o    (bin_o),
        .ladder_o (ladder_o),
        .iout_o   (iout_o),
        .iout_n_o (iout_n_o)
    );

    // {code, expected thermometer lines}
    localparam logic [26:0] VEC [8] = '{
        {12'h000, 15'h0000}, {12'hFFF, 15'h7FFF}, {12'h800, 15'h00FF},
        {12'h7FF, 15'h007F}, {12'h123, 15'h0001}, {12'hA5C, 15'h03FF},
        {12'h0C0, 15'h0000}, {12'hF3F, 15'h7FFF}
    };

    function automatic logic [14:0] fill(input int n);
        logic [15:0] t;
        t = (16'd1 << n) - 16'd1;
        return t[14:0];
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_word(input string tag, input logic [11:0] c);
        chk({tag, " R1 therm"}, int'(therm_o), int'(fill(int'(c[11:8]))));
        chk({tag, " R2 bin"}, int'(bin_o), int'(c[7:6]));
        chk({tag, " R3 ladder"}, int'(ladder_o), int'(c[5:0]));
        chk({tag, " R7 iout"}, int'(iout_o), int'(c));
        chk({tag, " R8 iout_n"}, int'(iout_n_o), 4095 - int'(c));
    endtask

    // Capture at edge k, le low at k+1, output due after k+3.
    task automatic write(input logic [11:0] c, input bit full);
        @(negedge clk); din = c; le = 1'b1;
        @(negedge clk); le = 1'b0;
        repeat (2) @(negedge clk);
        if (full) begin
            chk("R4 early iout", int'(iout_o), int'(last));
            chk("R4 early ladder", int'(ladder_o), int'(last[5:0]));
            chk("R4 early therm", int'(therm_o), int'(fill(int'(last[11:8]))));
        end
        @(negedge clk);
        last = c;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_word("reset state R9", 12'h000);

        // Table walk
        foreach (VEC[i]) begin
            write(VEC[i][26:15], 1'b1);
            chk("R1 table therm", int'(therm_o), int'(VEC[i][14:0]));
            expect_word("table", VEC[i][26:15]);
        end

        // R8 corner codes
        write(12'hFFF, 1'b1);
        chk("R8 all-ones true", int'(iout_o), 4095);
        chk("R8 all-ones comp", int'(iout_n_o), 0);
        write(12'h000, 1'b1);
        chk("R8 all-zeros true", int'(iout_o), 0);
        chk("R8 all-zeros comp", int'(iout_n_o), 4095);

        // R5 hold: le high, din keeps changing
        write(12'h5A3, 1'b0);
        @(negedge clk); le = 1'b1; din = 12'h9C1;
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            din = din + 12'h111;
            chk("R5 hold iout", int'(iout_o), 12'h5A3);
            chk("R5 hold therm", int'(therm_o), int'(fill(5)));
        end
        din = 12'h3E7;
        @(negedge clk); le = 1'b0;
        repeat (3) @(negedge clk);
        expect_word("R5 release", 12'h3E7);
        last = 12'h3E7;

        // R6 master register ignores din while le low
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            din = 12'hFFF - 12'(j * 100);
            chk("R6 closed master", int'(iout_o), 12'h3E7);
        end
        @(negedge clk);
        chk("R6 closed master ladder", int'(ladder_o), 6'h27);

        // R7 exhaustive sweep
        for (int c = 0; c < 4096; c++) begin
            write(12'(c), 1'b0);
            chk("R7 sweep iout", int'(iout_o), c);
            chk("R7 sweep count", $countones(therm_o), c >> 8);
            chk("R8 sweep sum", int'(iout_o) + int'(iout_n_o), 4095);
        end

        // R9 reset from a non-zero word
        write(12'hB6D, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        expect_word("R9 after reset", 12'h000);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        expect_word("R9 stays cleared", 12'h000);
        last = 12'h000;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule